// File: doc/BRIEF.md
# Interlocked Byte Talker

This block is the sending end of a byte-wide parallel bus on which one talker and any number of listeners exchange data through three control lines: a data-valid strobe driven by the talker, and two shared lines that report whether every listener is ready to take a byte and whether every listener has taken the current one. The two shared lines are wired-AND combinations, so a byte moves only as fast as the slowest listener on the bus.

Bytes come in from local logic over a valid/ready stream, each with a last-byte flag. For each byte the talker waits with data-valid low until every listener is ready and no listener still reports the previous byte as taken. It then drives the byte, lets it settle for a programmable number of clocks, and raises data-valid. The byte and its end-of-message tag are held until the taken line comes up. Data-valid is then dropped and the next byte begins. If the listeners never take the byte, a timeout ends the cycle and raises an error pulse.

Both listener lines are asynchronous to the talker's clock and pass through a synchronizer first. All reaction times below include that synchronizer.

Top module: `hs_talker`

## Requirements
- R1: While reset is asserted and right after it, bus_dav, bus_eom and tmo_err are 0, bus_data is all zeros and in_ready is 1.
- R2: in_ready is 1 only while the talker is idle. A byte is taken on a clock edge where in_valid and in_ready are both 1. in_ready stays 0 from that edge until data-valid has been released.
- R3: bus_dav stays 0 and bus_data stays all zeros while the synchronized all-ready line is 0 or the synchronized all-taken line is still 1.
- R4: Once the listeners are ready, the byte is driven on bus_data with bus_dav low for exactly settle_cycles+1 clocks. bus_dav then rises with that same byte on the bus.
- R5: While bus_dav is 1 and no taken indication has been seen, bus_data and bus_eom hold their values and bus_dav stays 1. The only exception is a timeout.
- R6: bus_dav falls SYNC_STAGES+1 clocks after lsn_taken_all rises, and no error is flagged.
- R7: bus_eom is 1 only while bus_dav is 1, and then it equals the in_last flag that came with the byte.
- R8: If bus_dav has been high for TMO_CYCLES clocks without a taken indication, bus_dav falls. In the same clock tmo_err is 1 for exactly one cycle, the byte is dropped and the talker returns to idle, ready for the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| settle_cycles | input | SETTLE_W | Extra clocks the data settles before data-valid |
| in_valid | input | 1 | Local stream: byte offered |
| in_ready | output | 1 | Local stream: talker can take a byte |
| in_data | input | DATA_W | Local stream: byte value |
| in_last | input | 1 | Local stream: final byte of the message |
| lsn_ready_all | input | 1 | Wired-AND: every listener ready for data (async) |
| lsn_taken_all | input | 1 | Wired-AND: every listener has taken the byte (async) |
| bus_data | output | DATA_W | Data lines, zero when not driven |
| bus_dav | output | 1 | Data-valid strobe |
| bus_eom | output | 1 | End-of-message tag, with data-valid on the last byte |
| tmo_err | output | 1 | One-cycle pulse when a byte times out |

## Verification
The assertions check the rules that hold on every clock. The talker never offers the stream ready while data-valid is up. Byte and tag stay frozen while the strobe waits for the taken line. The strobe drops on the clock after the synchronized taken line is seen. The end-of-message tag never appears without data-valid. The error is a single-cycle pulse that coincides with the strobe falling. Exact counts need the bench's scenarios, because they relate stimulus to the outputs across many clocks. These are the settle length for several programmed values, the synchronizer delay from taken to release, the full timeout window, and the gating by a listener that is not ready or is still reporting taken.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_SETTLE = 2'd2,
        ST_VALID  = 2'd3
    } hs_state_e;

endpackage

// File: rtl/hs_sync.sv
// Multi-stage synchronizer for asynchronous bus control lines.
module hs_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[i] <= '0;
                else        stage_q[i] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[i] <= '0;
                else        stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/hs_timer.sv
// Loadable down-counter shared by the settle and timeout phases.
module hs_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)               cnt_d = load_val;
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/hs_talker.sv
// Source side of a three-line interlocked byte handshake.
module hs_talker #(
    parameter int DATA_W      = 8,
    parameter int SETTLE_W    = 4,
    parameter int TMO_CYCLES  = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [DATA_W-1:0]   in_data,
    input  logic                in_last,
    input  logic                lsn_ready_all,
    input  logic                lsn_taken_all,
    output logic [DATA_W-1:0]   bus_data,
    output logic                bus_dav,
    output logic                bus_eom,
    output logic                tmo_err
);
    import hs_pkg::*;

    localparam int TMO_W = (TMO_CYCLES > 2) ? $clog2(TMO_CYCLES) : 1;
    localparam int CNT_W = (SETTLE_W > TMO_W) ? SETTLE_W : TMO_W;
    localparam logic [CNT_W-1:0] TMO_LOAD = CNT_W'(TMO_CYCLES - 1);

    typedef struct packed {
        hs_state_e         st;
        logic [DATA_W-1:0] byte_v;
        logic              last;
        logic              err;
    } regs_t;

    regs_t regs_d, regs_q;

    // Synchronized listener lines
    logic [1:0] lsn_sync;
    logic       ready_sync;
    logic       acc_sync;

    hs_sync #(
        .W      (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({lsn_ready_all, lsn_taken_all}),
        .dout  (lsn_sync)
    );

    assign ready_sync = lsn_sync[1];
    assign acc_sync   = lsn_sync[0];

    // Shared phase timer
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;

    hs_timer #(
        .W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    always_comb begin
        regs_d     = regs_q;
        regs_d.err = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;

        unique case (regs_q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    regs_d.byte_v = in_data;
                    regs_d.last   = in_last;
                    regs_d.st     = ST_WAIT;
                end
            end
            ST_WAIT: begin
                // all listeners ready and previous byte released
                if (ready_sync && !acc_sync) begin
                    regs_d.st = ST_SETTLE;
                    tmr_load  = 1'b1;
                    tmr_val   = CNT_W'(settle_cycles);
                end
            end
            ST_SETTLE: begin
                if (tmr_zero) begin
                    regs_d.st = ST_VALID;
                    tmr_load  = 1'b1;
                    tmr_val   = TMO_LOAD;
                end
            end
            ST_VALID: begin
                if (acc_sync) begin
                    regs_d.st = ST_IDLE;
                end else if (tmr_zero) begin
                    regs_d.st  = ST_IDLE;
                    regs_d.err = 1'b1;
                end
            end
            default: regs_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.st     <= ST_IDLE;
            regs_q.byte_v <= '0;
            regs_q.last   <= 1'b0;
            regs_q.err    <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    logic driving;
    assign driving  = (regs_q.st == ST_SETTLE) || (regs_q.st == ST_VALID);
    assign in_ready = (regs_q.st == ST_IDLE);
    assign bus_dav  = (regs_q.st == ST_VALID);
    assign bus_eom  = (regs_q.st == ST_VALID) && regs_q.last;
    assign bus_data = driving ? regs_q.byte_v : '0;
    assign tmo_err  = regs_q.err;

endmodule

// File: rtl/hs_talker_chk.sv
// Cycle-level rules of the talker, attached by bind.
module hs_talker_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic [DATA_W-1:0] bus_data,
    input logic              bus_dav,
    input logic              bus_eom,
    input logic              tmo_err,
    input logic              acc_sync
);

    // R2: stream is never offered ready while a byte is on the bus
    a_r2_busy_no_take: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dav |-> !in_ready);

    // R5: byte and tag frozen until taken (or timeout)
    a_r5_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_dav && !acc_sync) |=>
            ((bus_dav && $stable(bus_data) && $stable(bus_eom)) || tmo_err));

    // R6: strobe released on the clock after taken is seen
    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_dav && acc_sync) |=> (!bus_dav && !tmo_err));

    // R7: end tag only with data-valid
    a_r7_eom_with_dav: assert property (@(posedge clk) disable iff (!rst_n)
        bus_eom |-> bus_dav);

    // R8: error is a single pulse coinciding with the strobe falling
    a_r8_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_err |=> !tmo_err);

    a_r8_err_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_err |-> (!bus_dav && $past(bus_dav)));

    // R4: data-valid rises with the byte already on the bus
    a_r4_data_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_dav) |-> $stable(bus_data));

endmodule

bind hs_talker hs_talker_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .bus_data (bus_data),
    .bus_dav  (bus_dav),
    .bus_eom  (bus_eom),
    .tmo_err  (tmo_err),
    .acc_sync (acc_sync)
);

// File: tb/tb_hs_talker.sv
module tb_hs_talker;

    localparam int DATA_W = 8;
    localparam int SETTLE_W = 4;
    localparam int TMO = 16;
    localparam int SYNC = 2;

    logic                clk = 1'b0;
    logic                rst_n;
    logic [SETTLE_W-1:0] settle_cycles;
    logic                in_valid;
    logic                in_ready;
    logic [DATA_W-1:0]   in_data;
    logic                in_last;
    logic                lsn_ready_all;
    logic                lsn_taken_all;
    logic [DATA_W-1:0]   bus_data;
    logic                bus_dav;
    logic                bus_eom;
    logic                tmo_err;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    hs_talker #(
        .DATA_W      (DATA_W),
        .SETTLE_W    (SETTLE_W),
        .TMO_CYCLES  (TMO),
        .SYNC_STAGES (SYNC)
    ) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .settle_cycles (settle_cycles),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .in_data       (in_data),
        .in_last       (in_last),
        .lsn_ready_all (lsn_ready_all),
        .lsn_taken_all (lsn_taken_all),
        .bus_data      (bus_data),
        .bus_dav       (bus_dav),
        .bus_eom       (bus_eom),
        .tmo_err       (tmo_err)
    );

    typedef struct packed {
        logic [7:0] b;
        logic       last;
        logic [3:0] settle;
        logic [3:0] dly;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        '{8'hA5, 1'b0, 4'd0,  4'd0},
        '{8'h3C, 1'b0, 4'd1,  4'd2},
        '{8'h81, 1'b0, 4'd5,  4'd7},
        '{8'hFF, 1'b1, 4'd15, 4'd1},
        '{8'h01, 1'b0, 4'd3,  4'd10},
        '{8'h7E, 1'b1, 4'd2,  4'd4}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b, input logic last, input logic [3:0] s);
        @(negedge clk);
        settle_cycles = s;
        in_data       = b;
        in_last       = last;
        in_valid      = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 ready low after take", 32'(in_ready), 32'd0);
    endtask

    task automatic watch_settle(input logic [7:0] b, input logic last, input logic [3:0] s);
        int cnt = 0;
        int guard = 0;
        while (!bus_dav && guard < 2000) begin
            if (bus_data == b) cnt++;
            guard++;
            @(negedge clk);
        end
        chk("R4 settle length", 32'(cnt), 32'(s) + 32'd1);
        chk("R4 byte with dav", 32'(bus_data), 32'(b));
        chk("R7 eom tag", 32'(bus_eom), 32'(last));
        chk("R2 no ready while dav", 32'(in_ready), 32'd0);
    endtask

    task automatic finish_accept(input logic [7:0] b, input logic last, input logic [3:0] dly);
        int n = 0;
        int bad = 0;
        for (int i = 0; i < int'(dly); i++) begin
            @(negedge clk);
            if (!bus_dav || bus_data != b || bus_eom != last) bad++;
        end
        chk("R5 held until taken", 32'(bad), 32'd0);
        lsn_taken_all = 1'b1;
        do begin
            @(negedge clk);
            n++;
        end while (bus_dav && n < 50);
        chk("R6 release delay", 32'(n), 32'(SYNC + 1));
        chk("R6 no error", 32'(tmo_err), 32'd0);
        chk("R7 eom gone", 32'(bus_eom), 32'd0);
        lsn_taken_all = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst_n         = 1'b0;
        settle_cycles = '0;
        in_valid      = 1'b0;
        in_data       = '0;
        in_last       = 1'b0;
        lsn_ready_all = 1'b1;
        lsn_taken_all = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 dav", 32'(bus_dav), 32'd0);
        chk("R1 eom", 32'(bus_eom), 32'd0);
        chk("R1 err", 32'(tmo_err), 32'd0);
        chk("R1 data", 32'(bus_data), 32'd0);
        chk("R1 in_ready", 32'(in_ready), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", 32'(in_ready), 32'd1);

        // table walk
        for (int k = 0; k < 6; k++) begin
            push(VECS[k].b, VECS[k].last, VECS[k].settle);
            watch_settle(VECS[k].b, VECS[k].last, VECS[k].settle);
            finish_accept(VECS[k].b, VECS[k].last, VECS[k].dly);
        end

        // R3: listener not ready holds everything back
        begin
            int bad = 0;
            lsn_ready_all = 1'b0;
            repeat (4) @(negedge clk);
            push(8'h5A, 1'b0, 4'd1);
            repeat (12) begin
                @(negedge clk);
                if (bus_dav || bus_data != 0) bad++;
            end
            chk("R3 gated by not ready", 32'(bad), 32'd0);
            lsn_ready_all = 1'b1;
            watch_settle(8'h5A, 1'b0, 4'd1);
            finish_accept(8'h5A, 1'b0, 4'd2);
        end

        // R3: taken still asserted from previous byte holds next byte
        begin
            int bad = 0;
            lsn_taken_all = 1'b1;
            repeat (4) @(negedge clk);
            push(8'hC3, 1'b1, 4'd0);
            repeat (12) begin
                @(negedge clk);
                if (bus_dav || bus_data != 0) bad++;
            end
            chk("R3 gated by stale taken", 32'(bad), 32'd0);
            lsn_taken_all = 1'b0;
            watch_settle(8'hC3, 1'b1, 4'd0);
            finish_accept(8'hC3, 1'b1, 4'd3);
        end

        // R8: timeout
        begin
            int n = 0;
            push(8'h99, 1'b1, 4'd2);
            watch_settle(8'h99, 1'b1, 4'd2);
            while (bus_dav && n < 100) begin
                n++;
                @(negedge clk);
            end
            chk("R8 dav high window", 32'(n), 32'(TMO));
            chk("R8 err at fall", 32'(tmo_err), 32'd1);
            @(negedge clk);
            chk("R8 err one cycle", 32'(tmo_err), 32'd0);
            chk("R8 back to idle", 32'(in_ready), 32'd1);
            chk("R8 byte dropped", 32'(bus_data), 32'd0);
        end

        // R8: next byte after timeout goes through normally
        push(8'h42, 1'b0, 4'd1);
        watch_settle(8'h42, 1'b0, 4'd1);
        finish_accept(8'h42, 1'b0, 4'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule